// File: doc/BRIEF.md
# Master Status and Interrupt Aggregator

This block collects the status of a device's sub-blocks into a single host-readable word. Software reads that word first and uses it to find the detailed status registers it must service. Two of its bits are latched event flags that clear when the host reads them. One bit is a real-time flag that shows the present state of its source. An internal boundary generator counts reference-clock enable ticks and raises a one-second event. An error-counter saturation flag and a bit-error-rate tester change flag complete the word.

A read/write interrupt mask register selects which status bits drive the single active-high interrupt output. The host reaches both registers through a simple port: address, read strobe, write strobe, write data and registered read data. Reading the status word clears its latched bits and releases their interrupt, even when the source condition is still present. An event that arrives in the same cycle as that read is kept.

Top module: `mstat_hub`

## Requirements
- R1: The status word is at address 0x08. Bit 0 is the one-second flag, bit 1 is the saturation flag and bit 2 is the tester-change flag. Bits 7:3 read as zero. All bits are zero after reset. A read of any address other than 0x08 or 0x09 returns zero.
- R2: Bit 0 sets after the SEC_TICKS-th reference tick that follows reset. It sets again after every SEC_TICKS further ticks.
- R3: A read of 0x08 clears bit 0. Bit 0 stays clear until the next boundary.
- R4: Bit 1 sets one cycle after a rising edge on any line of the saturation input vector.
- R5: A read of 0x08 clears bit 1 even while a saturation line is still high. Bit 1 sets again only on a new rising edge.
- R6: Bit 2 is not latched. It is high in the cycle when the tester enable is high and at least one of these is true: the sync input differs from its value one cycle earlier, the bit-error pulse is high, or either overflow pulse is high.
- R7: Bit 2 and its interrupt contribution stay zero while the tester enable is low.
- R8: The mask register is at address 0x09. All 8 bits can be read and written. It resets to zero.
- R9: The interrupt output is high exactly when a status bit and its matching mask bit are both one. With a zero mask the output is low.
- R10: A read of 0x08 drops the interrupt caused by a latched bit in the cycle after the read, even while the source condition persists.
- R11: Writes to 0x08 do not change the status word.
- R12: If an event arrives in the same cycle as a clearing read, that read returns the value from before the read. The event stays latched for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle enable per reference-clock period |
| sat_i | input | NUM_SAT | Saturation levels of the error counters |
| tst_en_i | input | 1 | Tester interrupt enable |
| tst_sync_i | input | 1 | Tester receive-sync level |
| tst_bit_err_i | input | 1 | Tester bit-error pulse |
| tst_bcnt_ovf_i | input | 1 | Tester bit-counter overflow pulse |
| tst_ecnt_ovf_i | input | 1 | Tester error-counter overflow pulse |
| host_addr_i | input | ADDR_W | Host register address |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data, registered on a read strobe |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The boundary generator is driven with one tick fewer than a full period and then with a full period. This separates an off-by-one count from a correct one. It also shows that a read clears bit 0 until the next boundary. Saturation lines are raised on different lines and then held high. This separates detecting any edge from detecting any level, and clearing on read from following the level. A read that coincides with a new event shows whether that event is lost. Sync toggles, error pulses and overflow pulses are applied with the tester enable high and then low. Together with masked and unmasked interrupt checks, these separate real-time behaviour from latched behaviour.

// File: rtl/mstat_pkg.sv
// Shared constants for the master status aggregator: register addresses
// and the position of each flag in the status word.
package mstat_pkg;
    localparam logic [7:0] STAT_ADDR = 8'h08;
    localparam logic [7:0] MASK_ADDR = 8'h09;
    localparam int         BIT_SEC   = 0;
    localparam int         BIT_SAT   = 1;
    localparam int         BIT_TST   = 2;
    localparam int         NUM_LAT   = 2;
endpackage

// File: rtl/mstat_sec_gen.sv
// One-second boundary generator. Counts reference ticks and emits a
// one-cycle boundary pulse on every SEC_TICKS-th tick.
// Assumes ref_tick_i is a one-cycle enable in the clk domain.
module mstat_sec_gen #(
    parameter int SEC_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    output logic boundary_o
);
    localparam int CNT_W = (SEC_TICKS > 2) ? $clog2(SEC_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEC_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last    = (cnt_q == LAST);
    assign boundary_o = ref_tick_i & at_last;

    // Advance the tick counter, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (ref_tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/mstat_tst_det.sv
// Tester change detector. Flags a change in sync state, a bit error or a
// counter overflow, gated by the tester's interrupt enable. Output is
// combinational (real-time), not latched.
module mstat_tst_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sync_i,
    input  logic bit_err_i,
    input  logic bcnt_ovf_i,
    input  logic ecnt_ovf_i,
    output logic chg_o
);
    logic sync_q;

    // Remember last cycle's sync level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_i;
    end

    // Form the enabled change indication.
    always_comb begin
        chg_o = en_i & ((sync_i ^ sync_q) | bit_err_i | bcnt_ovf_i | ecnt_ovf_i);
    end
endmodule

// File: rtl/mstat_latch.sv
// Bank of clear-on-read event latches. A set in the same cycle as a clear
// wins, so no event is lost.
module mstat_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        // Hold, clear on read, set on event (set has priority).
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_i) | set_i[i];
        end
        assign q_o[i] = q;
    end
endmodule

// File: rtl/mstat_hub.sv
// Master status and interrupt aggregator (top). Builds the status word from
// latched and real-time flags, holds the interrupt mask and decodes host
// accesses. Assumes single-cycle read/write strobes and DATA_W >= 3.
module mstat_hub #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SEC_TICKS = 16,
    parameter int NUM_SAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic [NUM_SAT-1:0] sat_i,
    input  logic              tst_en_i,
    input  logic              tst_sync_i,
    input  logic              tst_bit_err_i,
    input  logic              tst_bcnt_ovf_i,
    input  logic              tst_ecnt_ovf_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              irq_o
);
    import mstat_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    logic                sec_evt, tst_chg, sat_evt, stat_rd;
    logic [NUM_SAT-1:0]  sat_q;
    logic [NUM_LAT-1:0]  lat_set, lat_q;
    logic [DATA_W-1:0]   stat_word, mask_q, rdata_q;

    mstat_sec_gen #(.SEC_TICKS(SEC_TICKS)) u_sec (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .boundary_o(sec_evt)
    );

    mstat_tst_det u_tst (
        .clk(clk), .rst_n(rst_n), .en_i(tst_en_i), .sync_i(tst_sync_i),
        .bit_err_i(tst_bit_err_i), .bcnt_ovf_i(tst_bcnt_ovf_i),
        .ecnt_ovf_i(tst_ecnt_ovf_i), .chg_o(tst_chg)
    );

    // Previous saturation levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sat_q <= '0;
        else        sat_q <= sat_i;
    end

    assign sat_evt = |(sat_i & ~sat_q);
    assign stat_rd = host_rd_i && (host_addr_i == A_STAT);

    // Route events onto their latch positions.
    always_comb begin
        lat_set          = '0;
        lat_set[BIT_SEC] = sec_evt;
        lat_set[BIT_SAT] = sat_evt;
    end

    mstat_latch #(.W(NUM_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .set_i(lat_set), .clr_i(stat_rd), .q_o(lat_q)
    );

    // Assemble the visible status word.
    always_comb begin
        stat_word          = '0;
        stat_word[BIT_SEC] = lat_q[BIT_SEC];
        stat_word[BIT_SAT] = lat_q[BIT_SAT];
        stat_word[BIT_TST] = tst_chg;
    end

    // Interrupt mask register, host writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mask_q <= '0;
        else if (host_wr_i && host_addr_i == A_MASK) mask_q <= host_wdata_i;
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (host_rd_i) begin
            if (host_addr_i == A_STAT)      rdata_q <= stat_word;
            else if (host_addr_i == A_MASK) rdata_q <= mask_q;
            else                            rdata_q <= '0;
        end
    end

    assign host_rdata_o = rdata_q;
    assign irq_o        = |(stat_word & mask_q);
endmodule

// File: rtl/mstat_hub_chk.sv
// Assertion checker for mstat_hub, attached by bind.
module mstat_hub_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NUM_SAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SAT-1:0] sat_i,
    input logic [NUM_SAT-1:0] sat_q,
    input logic              tst_en_i,
    input logic              sec_evt,
    input logic              stat_rd,
    input logic              host_wr_i,
    input logic [1:0]        lat_q,
    input logic [DATA_W-1:0] stat_word,
    input logic [DATA_W-1:0] mask_q,
    input logic              irq_o
);
    // R4: a saturation rising edge is latched next cycle
    assert_sat_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sat_i & ~sat_q)) |=> lat_q[1]);

    // R3: a read without a new boundary leaves bit 0 clear
    assert_sec_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sec_evt) |=> !lat_q[0]);

    // R12: an event coinciding with a read is not lost
    assert_no_lost_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && sec_evt) |=> lat_q[0]);

    // R7: the tester flag is silent while its enable is low
    assert_tst_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en_i |-> !stat_word[2]);

    // R9: a zero mask never raises the interrupt
    assert_mask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    // R11: latches hold when nothing sets or clears them, even on writes
    assert_hold_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && !stat_rd && !sec_evt && !(|(sat_i & ~sat_q))) |=> $stable(lat_q));

    // R2: boundary pulses are a single cycle wide
    assert_boundary_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> !sec_evt);
endmodule

bind mstat_hub mstat_hub_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SAT(NUM_SAT)) chk_i (
    .clk(clk), .rst_n(rst_n), .sat_i(sat_i), .sat_q(sat_q), .tst_en_i(tst_en_i),
    .sec_evt(sec_evt), .stat_rd(stat_rd), .host_wr_i(host_wr_i), .lat_q(lat_q),
    .stat_word(stat_word), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/mstat_hub_tb_top.sv
// Directed bench for mstat_hub. Tasks start and end at a falling edge.
module mstat_hub_tb_top;
    localparam int SEC_TICKS = 16;
    localparam int NUM_SAT   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic [NUM_SAT-1:0] sat = '0;
    logic              tst_en = 1'b0, tst_sync = 1'b0, tst_err = 1'b0;
    logic              tst_bovf = 1'b0, tst_eovf = 1'b0;
    logic [7:0]        addr = '0;
    logic              rd = 1'b0, wr = 1'b0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              irq;
    int                vecs = 0, errs = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    mstat_hub #(.SEC_TICKS(SEC_TICKS), .NUM_SAT(NUM_SAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .sat_i(sat),
        .tst_en_i(tst_en), .tst_sync_i(tst_sync), .tst_bit_err_i(tst_err),
        .tst_bcnt_ovf_i(tst_bovf), .tst_ecnt_ovf_i(tst_eovf),
        .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R9 irq after reset", {7'b0, irq}, 8'h00);
        host_read(8'h08, d); check("R1 status reset", d, 8'h00);
        host_read(8'h09, d); check("R8 mask reset", d, 8'h00);
        host_read(8'h3C, d); check("R1 unmapped read", d, 8'h00);
    endtask

    task automatic t_second();
        logic [7:0] d;
        ticks(SEC_TICKS - 1);
        host_read(8'h08, d); check("R2 before boundary", d, 8'h00);
        ticks(1);
        host_read(8'h08, d); check("R2 first boundary", d, 8'h01);
        host_read(8'h08, d); check("R3 cleared after read", d, 8'h00);
        ticks(SEC_TICKS - 1);
        host_read(8'h08, d); check("R3 stays clear", d, 8'h00);
        ticks(1);
        host_read(8'h08, d); check("R2 periodic boundary", d, 8'h01);
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        sat[0] = 1'b1;
        @(negedge clk);
        host_read(8'h08, d); check("R4 sat line 0", d, 8'h02);
        @(negedge clk);
        host_read(8'h08, d); check("R5 clear while held", d, 8'h00);
        sat[1] = 1'b1;
        @(negedge clk);
        host_read(8'h08, d); check("R4 sat line 1", d, 8'h02);
        sat[2] = 1'b1;
        host_read(8'h08, d); check("R12 read returns old value", d, 8'h00);
        host_read(8'h08, d); check("R12 coinciding event kept", d, 8'h02);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        host_write(8'h09, 8'hFF);
        host_read(8'h09, d); check("R8 mask readback", d, 8'hFF);
        host_write(8'h09, 8'h02);
        sat[3] = 1'b1;
        @(negedge clk);
        check("R9 masked irq raised", {7'b0, irq}, 8'h01);
        host_write(8'h08, 8'h00);
        host_read(8'h08, d); check("R11 write ignored", d, 8'h02);
        check("R10 irq released by read", {7'b0, irq}, 8'h00);
        host_write(8'h08, 8'hFF);
        host_read(8'h08, d); check("R11 write of ones ignored", d, 8'h00);
        host_write(8'h09, 8'h01);
        sat = '0;
        @(negedge clk);
        sat[0] = 1'b1;
        @(negedge clk);
        check("R9 unmasked bit gives no irq", {7'b0, irq}, 8'h00);
        host_read(8'h08, d);
    endtask

    task automatic t_tester();
        logic [7:0] d;
        host_write(8'h09, 8'h04);
        tst_en = 1'b1; tst_sync = 1'b1;
        #1 check("R6 sync gain irq", {7'b0, irq}, 8'h01);
        host_read(8'h08, d); check("R6 sync gain flag", d, 8'h04);
        host_read(8'h08, d); check("R6 not latched", d, 8'h00);
        tst_err = 1'b1;
        host_read(8'h08, d); check("R6 bit error", d, 8'h04);
        tst_err = 1'b0; tst_eovf = 1'b1;
        host_read(8'h08, d); check("R6 error counter overflow", d, 8'h04);
        tst_eovf = 1'b0; tst_bovf = 1'b1;
        host_read(8'h08, d); check("R6 bit counter overflow", d, 8'h04);
        tst_bovf = 1'b0; tst_sync = 1'b0;
        host_read(8'h08, d); check("R6 sync loss", d, 8'h04);
        tst_en = 1'b0; tst_err = 1'b1; tst_sync = 1'b1;
        #1 check("R7 disabled irq", {7'b0, irq}, 8'h00);
        host_read(8'h08, d); check("R7 disabled flag", d, 8'h00);
        tst_err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_second();
        t_saturate();
        t_irq();
        t_tester();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vecs++; errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule